// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block receives serial words in half-duplex synchronous slave mode. An external master drives the serial clock, and the block samples the data line on each rising edge of that clock. Both lines are first passed through a two-flop synchroniser into the system clock domain. Bits arrive least-significant first. A word is 8 bits long, or 9 bits when nine-bit mode is selected. The ninth bit is kept in its own status output.

When a word is complete it moves from the shift register into a one-word holding register, and a receive-complete flag is set. Reading the holding register clears the flag. The flag drives an interrupt request when the interrupt enable is set. While the host sleeps, reception continues, and the enabled interrupt also appears as a wake request.

If a word completes while the previous one is still unread, an overrun latches. During an overrun nothing more is shifted in or transferred. The overrun clears only when receive-enable is taken low. Taking receive-enable low also drops any partly received word.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, data_o, bit9_o, done_o, ovr_o, irq_o and wake_o are all 0.
- R2: Words are received only while rx_en_i is 1. single_en_i has no effect on reception.
- R3: When the last bit of a word is sampled, the word is placed on data_o with bit i taken from the (i+1)-th sampled bit (LSB first), and done_o is set.
- R4: With nine_bit_i=1 a word is 9 bits long and its ninth bit appears on bit9_o. With nine_bit_i=0 a word is 8 bits long and bit9_o is 0.
- R5: irq_o is 1 exactly while done_o and irq_en_i are both 1.
- R6: Reception works the same while sleep_i is 1, and wake_o is 1 while both irq_o and sleep_i are 1.
- R7: A one-cycle pulse on rd_i clears done_o.
- R8: If a word completes while done_o is 1 (and rd_i is not pulsed in that cycle), ovr_o becomes 1 and data_o keeps the earlier word.
- R9: While ovr_o is 1, no word reaches the holding register, even if done_o has been cleared. ovr_o stays 1 until rx_en_i is 0, and clears then.
- R10: Taking rx_en_i to 0 discards a partly received word, so the next word after re-enable starts at bit 0.
- R11: Data is sampled at the rising edge of ser_clk_i as seen after the two-flop synchroniser. Each clock phase must last at least 3 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock driven by the external master |
| ser_data_i | input | 1 | Serial data line |
| rx_en_i | input | 1 | Continuous receive enable; a low level clears overrun |
| single_en_i | input | 1 | Single-receive enable; ignored in slave mode |
| nine_bit_i | input | 1 | Selects 9-bit words |
| irq_en_i | input | 1 | Receive interrupt enable |
| sleep_i | input | 1 | Host is in low-power state |
| rd_i | input | 1 | Holding register read strobe |
| data_o | output | 8 | Received data word |
| bit9_o | output | 1 | Ninth received bit |
| done_o | output | 1 | Receive-complete flag |
| ovr_o | output | 1 | Overrun error |
| irq_o | output | 1 | Receive interrupt request |
| wake_o | output | 1 | Wake request while sleeping |

## Verification
On every cycle, the assertions check three things. The bit counter stays in range and moves only on a synchronised clock edge. The counter is cleared whenever reception is disabled. An overrun freezes the holding register until receive-enable drops. They also check that the flag rises only after a completed word, that a read clears it, and that the interrupt and wake outputs never appear without the flag. Other behaviour shows only in the bench's scenarios: LSB-first assembly of random 8- and 9-bit words, the discarding of a partial word, reception while sleeping, and recovery after an overrun once the enable is toggled.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              extra;
    logic [DATA_W-1:0] data;
  } word_s;
endpackage

// File: rtl/sync_rx_sync.sv
module sync_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_clk_i,
  input  logic ser_data_i,
  output logic rise_o,
  output logic bit_o
);
  logic [STAGES:0]   ck_q;
  logic [STAGES-1:0] dt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_q <= '0;
      dt_q <= '0;
    end else begin
      ck_q <= {ck_q[STAGES-1:0], ser_clk_i};
      dt_q <= {dt_q[STAGES-2:0], ser_data_i};
    end
  end

  // edge seen on the last synchronised stage
  assign rise_o = ck_q[STAGES-1] & ~ck_q[STAGES];
  assign bit_o  = dt_q[STAGES-1];

  p_rise_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift
  import sync_rx_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  hold_i,
  input  logic  nine_i,
  input  logic  rise_i,
  input  logic  bit_i,
  output word_s word_o,
  output logic  done_o
);
  localparam int CNT_W = $clog2(W + 2);

  logic [CNT_W-1:0] cnt_q, last;
  logic [W:0]       sr_q, sr_nxt;
  word_s            word_q;
  logic             done_q;

  assign last = nine_i ? CNT_W'(W) : CNT_W'(W - 1);

  always_comb begin
    sr_nxt = sr_q;
    for (int i = 0; i <= W; i++)
      if (cnt_q == CNT_W'(i)) sr_nxt[i] = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sr_q   <= '0;
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;
        sr_q  <= '0;
      end else if (rise_i && !hold_i) begin
        if (cnt_q >= last) begin
          word_q.data  <= sr_nxt[W-1:0];
          word_q.extra <= nine_i & sr_nxt[W];
          done_q       <= 1'b1;
          cnt_q        <= '0;
          sr_q         <= '0;
        end else begin
          sr_q  <= sr_nxt;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign word_o = word_q;
  assign done_o = done_q;

  p_cnt_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(W));
  p_cnt_on_edge_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_q) |-> ($past(rise_i) || !$past(en_i)));
  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sync_rx_hold.sv
module sync_rx_hold
  import sync_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rd_i,
  input  logic              word_done_i,
  input  word_s             word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              flag_o,
  output logic              ovr_o
);
  word_s hold_q;
  logic  flag_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (rd_i) flag_q <= 1'b0;
      if (!en_i) ovr_q <= 1'b0;
      else if (word_done_i && !ovr_q) begin
        if (flag_q && !rd_i) ovr_q <= 1'b1;  // word discarded
        else begin
          hold_q <= word_i;
          flag_q <= 1'b1;
        end
      end
    end
  end

  assign data_o = hold_q.data;
  assign bit9_o = hold_q.extra;
  assign flag_o = flag_q;
  assign ovr_o  = ovr_q;

  p_ovr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && en_i) |=> ovr_q);
  p_ovr_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> $stable(hold_q));
  p_flag_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(word_done_i));
  p_rd_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !word_done_i) |=> !flag_q);
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sync_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              rx_en_i,
  input  logic              single_en_i,
  input  logic              nine_bit_i,
  input  logic              irq_en_i,
  input  logic              sleep_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              done_o,
  output logic              ovr_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic  rise, sbit, word_done, ovr;
  word_s word;
  logic  unused_single;

  assign unused_single = single_en_i;  // no meaning in slave mode

  sync_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ser_clk_i, .ser_data_i,
    .rise_o(rise), .bit_o(sbit)
  );

  sync_rx_shift #(.W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .en_i(rx_en_i), .hold_i(ovr), .nine_i(nine_bit_i),
    .rise_i(rise), .bit_i(sbit), .word_o(word), .done_o(word_done)
  );

  sync_rx_hold u_hold (
    .clk_i, .rst_ni, .en_i(rx_en_i), .rd_i, .word_done_i(word_done),
    .word_i(word), .data_o, .bit9_o, .flag_o(done_o), .ovr_o(ovr)
  );

  assign ovr_o  = ovr;
  assign irq_o  = done_o & irq_en_i;
  assign wake_o = irq_o & sleep_i;

  p_irq_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);
  p_wake_sleep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (done_o && sleep_i));
endmodule

// File: tb/sim_sync_slave_rx.sv
module sim_sync_slave_rx;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_ni = 0;
  logic ser_clk = 0, ser_data = 0, rx_en = 0, single_en = 0;
  logic nine = 0, irq_en = 0, sleep = 0, rd = 0;
  logic [7:0] data_o;
  logic bit9_o, done_o, ovr_o, irq_o, wake_o;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_slave_rx u0 (
    .clk_i(clk), .rst_ni, .ser_clk_i(ser_clk), .ser_data_i(ser_data),
    .rx_en_i(rx_en), .single_en_i(single_en), .nine_bit_i(nine),
    .irq_en_i(irq_en), .sleep_i(sleep), .rd_i(rd),
    .data_o, .bit9_o, .done_o, .ovr_o, .irq_o, .wake_o
  );

  function automatic logic [7:0] exp_data(logic [8:0] w);
    return w[7:0];
  endfunction
  function automatic logic exp_bit9(logic [8:0] w, logic n);
    return n ? w[8] : 1'b0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); ser_clk = 0; ser_data = b;
    repeat (4) @(negedge clk);
    ser_clk = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_word(logic [8:0] w, int nb);
    for (int i = 0; i < nb; i++) send_bit(w[i]);
    @(negedge clk); ser_clk = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
  endtask

  task automatic toggle_en();
    @(negedge clk); rx_en = 0;
    repeat (2) @(negedge clk);
    rx_en = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [8:0] w;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 data", data_o, 0); chk("R1 done", done_o, 0);
    chk("R1 ovr", ovr_o, 0);   chk("R1 irq", irq_o, 0);
    chk("R1 bit9", bit9_o, 0); chk("R1 wake", wake_o, 0);
    rst_ni = 1;
    @(negedge clk);

    // R2 single enable ignored, receiver off
    single_en = 1;
    send_word(9'h0A5, 8);
    chk("R2 no rx without enable", done_o, 0);
    chk("R2 data untouched", data_o, 0);
    single_en = 0;

    // R3 directed LSB-first word
    rx_en = 1;
    send_word(9'h0B4, 8);
    chk("R3 flag", done_o, 1);
    chk("R3 data", data_o, 8'hB4);
    chk("R5 irq off when disabled", irq_o, 0);
    irq_en = 1; @(negedge clk);
    chk("R5 irq on", irq_o, 1);
    do_read();
    chk("R7 read clears flag", done_o, 0);
    chk("R5 irq follows flag", irq_o, 0);

    // R4 R3 random words in both modes
    for (int k = 0; k < 24; k++) begin
      w = 9'($urandom);
      nine = 1'($urandom);
      send_word(w, nine ? 9 : 8);
      chk("R3 rand data", data_o, exp_data(w));
      chk("R4 rand bit9", bit9_o, exp_bit9(w, nine));
      chk("R3 rand flag", done_o, 1);
      do_read();
    end
    nine = 0;

    // R6 reception in sleep, wake request
    sleep = 1;
    send_word(9'h13C, 8);
    chk("R6 data in sleep", data_o, 8'h3C);
    chk("R6 wake", wake_o, 1);
    irq_en = 0; @(negedge clk);
    chk("R6 no wake without irq", wake_o, 0);
    do_read(); sleep = 0; irq_en = 1;

    // R8 overrun
    send_word(9'h011, 8);
    send_word(9'h022, 8);
    chk("R8 ovr set", ovr_o, 1);
    chk("R8 data kept", data_o, 8'h11);
    // R9 no transfer during overrun even after read
    do_read();
    send_word(9'h033, 8);
    chk("R9 no new flag", done_o, 0);
    chk("R9 data frozen", data_o, 8'h11);
    chk("R9 ovr sticky", ovr_o, 1);
    @(negedge clk); rx_en = 0; @(negedge clk);
    chk("R9 ovr cleared by disable", ovr_o, 0);
    rx_en = 1; @(negedge clk);
    send_word(9'h044, 8);
    chk("R9 rx after re-enable", data_o, 8'h44);
    do_read();

    // R10 partial word dropped
    send_bit(1); send_bit(1); send_bit(0);
    toggle_en();
    send_word(9'h0C9, 8);
    chk("R10 partial dropped", data_o, 8'hC9);
    do_read();

    // R11 only rising edges sample: a high level held long is one bit
    @(negedge clk); ser_data = 1; ser_clk = 1;
    repeat (20) @(negedge clk);
    ser_clk = 0; repeat (4) @(negedge clk);
    for (int i = 1; i < 8; i++) send_bit(1'(8'h5A >> i));
    @(negedge clk); ser_clk = 0; repeat (2) @(negedge clk);
    chk("R11 one bit per rise", data_o, 8'h5B);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule